// File: doc/BRIEF.md
# Redundant Reference Clock Selector

This block picks one of four candidate reference clocks for a downstream frequency synthesizer and keeps a sticky failure alarm for each candidate. Every candidate carries a qualifier bit and a raw fault indication from an external sensing stage. The phase detector also reports a phase fault against the reference currently in use. After master reset the block uses a configured primary input. In automatic mode it moves to another eligible, healthy input when the one in use fails. The input in use is reported as a 2-bit code.

Alarms can be cleared in two ways. A falling edge on an asynchronous clear pin clears every alarm and puts the selection back on the primary input. A register-style write clears individual alarms and leaves the selection where it is. When no usable input is left, the lock indication drops. It stays low until a master reset, even after inputs come back.

Top module: `refsel_top`

## Requirements
- R1: During and right after master reset (`rst_n` low, synchronous), `sel_code` equals `primary_sel`, `alarm_ok` is 4'b1111 and `lock` is 1, provided at least one input is usable.
- R2: With `qual_en` = 1 the eligibility vector `eligible` equals `qual`. With `qual_en` = 0 it is 4'b1111. In automatic mode an ineligible input is never kept as the selection. A raw fault on an ineligible input leaves its `alarm_ok` bit at 1.
- R3: A raw fault sampled on an eligible input at a clock edge drives that input's `alarm_ok` bit to 0 (0 = failed) at that same edge.
- R4: A cleared `alarm_ok` bit stays 0 after the fault goes away, until one of the two clear paths acts on it.
- R5: A falling edge on `alarm_clr_n` passes through a two-flop synchronizer and an edge detector. It takes effect at the third rising clock edge after the pin falls. It sets all four `alarm_ok` bits to 1 and returns `sel_code` to `primary_sel`.
- R6: A cycle with `reg_wr` = 1 clears the alarm of every input whose `reg_wdata` bit is 0. Bits written as 1 have no effect. `sel_code` does not change.
- R7: In automatic mode (`auto_en` = 1), when the input in use is no longer usable, the selection moves one edge after the alarm registers. It moves to the first usable input in ascending cyclic order after the current one. A usable input is one that is eligible and has `alarm_ok` = 1. Codes 00, 01, 10 and 11 name inputs 0 to 3.
- R8: When no input is usable, `lock` falls to 0 at the next edge. It stays 0 through alarm clears and restored inputs until a master reset.
- R9: A phase fault sampled at edge t marks the input in use at t as failed at edge t+P, where P is the parameter `DIV_P`. Further phase faults are ignored while one is pending.
- R10: If a fault and a clear hit the same input in the same cycle, the fault wins and the alarm reads failed. This applies to both clear paths.
- R11: With `auto_en` = 0, `sel_code` follows `primary_sel` one edge later, and no failover happens. Alarms are still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| auto_en | input | 1 | 1 = automatic failover, 0 = manual (follow primary) |
| primary_sel | input | 2 | Primary input code |
| qual_en | input | 1 | 1 = use qualifier bits, 0 = all inputs eligible |
| qual | input | 4 | Per-input qualifier bit |
| raw_fault | input | 4 | Per-input fault indication from the sensing stage |
| phase_err | input | 1 | Phase fault against the input in use |
| alarm_clr_n | input | 1 | Asynchronous global alarm clear, falling-edge active |
| reg_wr | input | 1 | Alarm-clear register write strobe |
| reg_wdata | input | 4 | Per-input clear bits, 0 = clear |
| sel_code | output | 2 | Input in use |
| alarm_ok | output | 4 | Per-input status, 0 = failed (sticky) |
| eligible | output | 4 | Effective qualifier per input |
| lock | output | 1 | 0 once no usable input has been left |

## Verification
The bench sweeps every primary input against every qualifier mask. It checks the starting selection and where a single failure leads. A wrong cyclic search would land on the wrong code, or on an unqualified input. Exact-cycle checks catch a synchronizer that acts one edge early or late, and a phase timer off by one from P. Collision cases catch a clear that beats a simultaneous fault. Separate cases show that the register clear leaves the selection alone and that a lost lock survives a global clear. A design wrong in either would move the selection, or raise lock again without a master reset.

// File: rtl/refsel_pkg.sv
// Shared types and helpers for the reference clock selector.
// Assumes exactly four candidates, coded on two bits.
package refsel_pkg;

    localparam int NUM_IN = 4;
    localparam int SEL_W  = 2;

    typedef logic [NUM_IN-1:0] in_vec_t;
    typedef logic [SEL_W-1:0]  sel_t;

    // First usable input after cur in ascending cyclic order; cur if none.
    function automatic sel_t next_usable(input in_vec_t usable, input sel_t cur);
        sel_t result;
        logic found;
        result = cur;
        found  = 1'b0;
        for (int k = 1; k < NUM_IN; k++) begin
            sel_t idx;
            idx = cur + sel_t'(k);
            if (!found && usable[idx]) begin
                result = idx;
                found  = 1'b1;
            end
        end
        return result;
    endfunction

endpackage

// File: rtl/refsel_clr_sync.sv
// Synchronizes the asynchronous global clear pin and produces a one-cycle
// pulse on its falling edge. Assumes the pin idles high; all stages reset high.
module refsel_clr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall_pulse
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the pin through the synchronizer and keep the last value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_n};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // A falling edge is a high-to-low step at the synchronizer output.
    always_comb fall_pulse = prev_q & ~sync_q[STAGES-1];

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |=> !fall_pulse);

endmodule

// File: rtl/refsel_phase_timer.sv
// Turns a phase fault on the input in use into a failure strobe on that
// input exactly DIV_P cycles later. Assumes DIV_P >= 1. One fault is
// tracked at a time.
module refsel_phase_timer
    import refsel_pkg::*;
#(
    parameter int DIV_P = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    phase_err,
    input  sel_t    sel,
    output in_vec_t phase_hit
);

    localparam int CNT_W = $clog2(DIV_P + 1);

    logic [CNT_W-1:0] cnt_q;
    sel_t             tgt_q;

    // Load the window on a new phase fault, then count it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tgt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (phase_err) begin
            cnt_q <= CNT_W'(DIV_P);
            tgt_q <= sel;
        end
    end

    // Strobe the latched target in the last cycle of the window.
    always_comb begin
        phase_hit = '0;
        if (cnt_q == CNT_W'(1))
            phase_hit[tgt_q] = 1'b1;
    end

    p_hit_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phase_hit));
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DIV_P));

endmodule

// File: rtl/refsel_alarm_bank.sv
// Sticky per-input failure flags (1 = failed). A set beats a clear in the
// same cycle. The global clear clears all flags; a register write clears
// the flags whose data bit is 0.
module refsel_alarm_bank
    import refsel_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  in_vec_t eligible,
    input  in_vec_t raw_fault,
    input  in_vec_t phase_hit,
    input  logic    clr_all,
    input  logic    reg_wr,
    input  in_vec_t reg_wdata,
    output in_vec_t fail_q
);

    in_vec_t set_vec;
    in_vec_t clr_vec;

    // Work out which flags are set and which are cleared this cycle.
    always_comb begin
        set_vec = (raw_fault & eligible) | phase_hit;
        if (clr_all)
            clr_vec = '1;
        else if (reg_wr)
            clr_vec = ~reg_wdata;
        else
            clr_vec = '0;
    end

    // Update the flags; a set overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fail_q <= '0;
        else
            fail_q <= (fail_q & ~clr_vec) | set_vec;
    end

    for (genvar i = 0; i < NUM_IN; i++) begin : g_chk
        p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (fail_q[i] && !clr_all && !(reg_wr && !reg_wdata[i])) |=> fail_q[i]);
        p_fault_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (raw_fault[i] && eligible[i]) |=> fail_q[i]);
        p_unqual_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!eligible[i] && !phase_hit[i] && !fail_q[i]) |=> !fail_q[i]);
    end

endmodule

// File: rtl/refsel_select_fsm.sv
// Holds the selected input and the loss-of-lock state. In automatic mode it
// moves to the next usable input in cyclic order when the current one becomes
// unusable. Loss of lock is left only through master reset.
module refsel_select_fsm
    import refsel_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    auto_en,
    input  sel_t    primary,
    input  in_vec_t usable,
    input  logic    clr_all,
    output sel_t    sel_q,
    output logic    lost_q
);

    logic any_usable;

    // Note whether any input is still usable.
    always_comb any_usable = |usable;

    // Selection and loss-of-lock update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= primary;
            lost_q <= 1'b0;
        end else begin
            if (!any_usable)
                lost_q <= 1'b1;
            if (!auto_en || clr_all)
                sel_q <= primary;
            else if (!lost_q && !usable[sel_q] && any_usable)
                sel_q <= next_usable(usable, sel_q);
        end
    end

    p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lost_q |=> lost_q);
    p_failover_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !clr_all && !lost_q && !usable[sel_q] && any_usable)
        |=> (sel_q != $past(sel_q)));
    p_sel_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !clr_all && !lost_q && usable[sel_q]) |=> $stable(sel_q));
    p_manual_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> (sel_q == $past(primary)));
    p_clr_primary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (sel_q == $past(primary)));

endmodule

// File: rtl/refsel_top.sv
// Redundant reference clock selector: four candidates, sticky alarms with a
// global and a per-bit clear path, cyclic automatic failover, loss-of-lock
// flag. Assumes raw_fault, qual and phase_err are already synchronous to clk.
module refsel_top
    import refsel_pkg::*;
#(
    parameter int DIV_P       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_en,
    input  logic [1:0] primary_sel,
    input  logic       qual_en,
    input  logic [3:0] qual,
    input  logic [3:0] raw_fault,
    input  logic       phase_err,
    input  logic       alarm_clr_n,
    input  logic       reg_wr,
    input  logic [3:0] reg_wdata,
    output logic [1:0] sel_code,
    output logic [3:0] alarm_ok,
    output logic [3:0] eligible,
    output logic       lock
);

    in_vec_t elig_vec;
    in_vec_t fail_vec;
    in_vec_t usable_vec;
    in_vec_t phase_vec;
    sel_t    sel_vec;
    logic    clr_pulse;
    logic    lost;

    // Effective eligibility and usability of each input.
    always_comb begin
        elig_vec   = qual_en ? qual : '1;
        usable_vec = elig_vec & ~fail_vec;
    end

    refsel_clr_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_n      (alarm_clr_n),
        .fall_pulse (clr_pulse)
    );

    refsel_phase_timer #(.DIV_P(DIV_P)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_err (phase_err),
        .sel       (sel_vec),
        .phase_hit (phase_vec)
    );

    refsel_alarm_bank u_alarms (
        .clk       (clk),
        .rst_n     (rst_n),
        .eligible  (elig_vec),
        .raw_fault (raw_fault),
        .phase_hit (phase_vec),
        .clr_all   (clr_pulse),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .fail_q    (fail_vec)
    );

    refsel_select_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .auto_en (auto_en),
        .primary (primary_sel),
        .usable  (usable_vec),
        .clr_all (clr_pulse),
        .sel_q   (sel_vec),
        .lost_q  (lost)
    );

    // Drive the outputs.
    always_comb begin
        sel_code = sel_vec;
        alarm_ok = ~fail_vec;
        eligible = elig_vec;
        lock     = ~lost;
    end

    p_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !qual_en |-> (eligible == 4'hF));
    p_lock_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (usable_vec == '0) |=> !lock);

endmodule

// File: tb/test_refsel_top.sv
// Self-checking bench: sweeps primary input against qualifier masks, then
// targeted cases for clears, phase faults, collisions, manual mode and lock.
module test_refsel_top;

    localparam int P = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       auto_en;
    logic [1:0] primary_sel;
    logic       qual_en;
    logic [3:0] qual;
    logic [3:0] raw_fault;
    logic       phase_err;
    logic       alarm_clr_n;
    logic       reg_wr;
    logic [3:0] reg_wdata;
    logic [1:0] sel_code;
    logic [3:0] alarm_ok;
    logic [3:0] eligible;
    logic       lock;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    refsel_top #(.DIV_P(P), .SYNC_STAGES(2)) i_refsel_top (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .primary_sel(primary_sel),
        .qual_en(qual_en), .qual(qual), .raw_fault(raw_fault), .phase_err(phase_err),
        .alarm_clr_n(alarm_clr_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .sel_code(sel_code), .alarm_ok(alarm_ok), .eligible(eligible), .lock(lock)
    );

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int nxt(input int mask, input int from);
        for (int k = 1; k < 4; k++) begin
            int idx;
            idx = (from + k) % 4;
            if (mask[idx]) return idx;
        end
        return from;
    endfunction

    task automatic do_reset(input int prim, input int msk, input bit qen);
        rst_n = 1'b0; auto_en = 1'b1; primary_sel = 2'(prim);
        qual_en = qen; qual = 4'(msk); raw_fault = '0; phase_err = 1'b0;
        alarm_clr_n = 1'b1; reg_wr = 1'b0; reg_wdata = '1;
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic fault_pulse(input int mask);
        raw_fault = 4'(mask);
        step(1);
        raw_fault = '0;
    endtask

    initial begin
        // R1: reset state with all inputs usable
        do_reset(2, 15, 1'b1);
        chk("R1 sel", sel_code, 2);
        chk("R1 alarm_ok", alarm_ok, 15);
        chk("R1 lock", lock, 1);
        step(3);
        chk("R1 sel held", sel_code, 2);

        // R2/R7/R8: sweep primary against qualifier masks, then fail the active input
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 16; m++) begin
                int s;
                int rem;
                do_reset(p, m, 1'b1);
                step(3);
                chk("R2 eligible", eligible, m);
                if (m == 0) begin
                    chk("R8 no usable input", lock, 0);
                end else begin
                    s = m[p] ? p : nxt(m, p);
                    chk("R2/R7 start sel", sel_code, s);
                    chk("R8 lock", lock, 1);
                    fault_pulse(1 << s);
                    chk("R3 alarm set", alarm_ok, 15 & ~(1 << s));
                    step(1);
                    rem = m & ~(1 << s);
                    if (rem == 0)
                        chk("R8 lock lost", lock, 0);
                    else
                        chk("R7 failover target", sel_code, nxt(rem, s));
                end
            end
        end

        // R2: qualifier disabled makes all eligible; unqualified fault ignored
        do_reset(1, 0, 1'b0);
        step(1);
        chk("R2 qual off", eligible, 15);
        chk("R2 qual off sel", sel_code, 1);
        do_reset(1, 4'b1110, 1'b1);
        step(1);
        fault_pulse(1);
        step(1);
        chk("R2 unqualified fault ignored", alarm_ok, 15);

        // R3/R4/R7: two faults, alarms stay after fault removed
        do_reset(0, 15, 1'b1);
        step(1);
        fault_pulse(1);
        step(1);
        chk("R7 sel after 0 fails", sel_code, 1);
        fault_pulse(2);
        step(3);
        chk("R4 sticky", alarm_ok, 4'b1100);
        chk("R7 sel after 1 fails", sel_code, 2);

        // R6: register clear of bit 0 only, selection unchanged
        reg_wr = 1'b1; reg_wdata = 4'b1110;
        step(1);
        reg_wr = 1'b0; reg_wdata = '1;
        chk("R6 one flag cleared", alarm_ok, 4'b1101);
        step(2);
        chk("R6 sel unchanged", sel_code, 2);

        // R5: global clear timing and return to primary
        alarm_clr_n = 1'b0;
        step(2);
        chk("R5 not yet applied", alarm_ok, 4'b1101);
        step(1);
        chk("R5 all cleared", alarm_ok, 15);
        chk("R5 back to primary", sel_code, 0);
        step(2);
        alarm_clr_n = 1'b1;
        step(3);
        chk("R5 rising edge no effect", sel_code, 0);

        // R10: fault wins against register clear
        reg_wr = 1'b1; reg_wdata = 4'b0111; raw_fault = 4'b1000;
        step(1);
        reg_wr = 1'b0; reg_wdata = '1; raw_fault = '0;
        chk("R10 fault beats reg clear", alarm_ok, 4'b0111);
        // R10: fault wins against global clear arriving the same edge
        alarm_clr_n = 1'b0;
        step(2);
        raw_fault = 4'b0010;
        step(1);
        raw_fault = '0;
        chk("R10 fault beats global clear", alarm_ok, 4'b1101);
        alarm_clr_n = 1'b1;
        step(3);

        // R9: phase fault declared exactly P edges later on input in use
        do_reset(3, 15, 1'b1);
        step(1);
        phase_err = 1'b1;
        step(1);
        phase_err = 1'b0;
        step(P - 1);
        chk("R9 not early", alarm_ok, 15);
        step(1);
        chk("R9 declared at P", alarm_ok, 4'b0111);
        step(1);
        chk("R9 failover", sel_code, 0);

        // R11: manual mode follows primary, no failover
        do_reset(2, 15, 1'b1);
        auto_en = 1'b0;
        step(1);
        fault_pulse(4);
        step(3);
        chk("R11 alarm recorded", alarm_ok, 4'b1011);
        chk("R11 no failover", sel_code, 2);
        primary_sel = 2'd3;
        step(1);
        chk("R11 follows primary", sel_code, 3);

        // R8: lost lock survives global clear, recovers by master reset
        do_reset(0, 15, 1'b1);
        step(1);
        fault_pulse(15);
        step(1);
        chk("R8 all failed", lock, 0);
        alarm_clr_n = 1'b0;
        step(4);
        alarm_clr_n = 1'b1;
        chk("R8 flags cleared", alarm_ok, 15);
        chk("R8 lock still low", lock, 0);
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
        step(1);
        chk("R8 lock after reset", lock, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule